// File: doc/BRIEF.md
# Receive Buffer Descriptor Ring Engine

This block takes bytes from a serial receiver and stores them into buffers that a host has set up in a table of 16-bit descriptors. Each descriptor is four words at a four-word stride from a programmable table base. The first word carries the control and status flags. The second word takes the stored byte count. The last two words hold the buffer address. The engine claims a descriptor only when its empty flag is set. It fills the buffer and closes the descriptor by writing back the count and status, then moves on. It returns to the table base after a descriptor marked as last.

The host reaches both the descriptor table and the byte-wide data memory through one synchronous port. A receive-buffer event flag, gated by a mask, drives an interrupt output. A one-cycle hunt command closes a partially filled buffer. A single-byte holding register sits between the receiver and memory. A byte that finds the holding register still occupied is dropped and reported as an overrun.

Top module: `rxbd_ring`

## Requirements
- R1: After a synchronous reset the event flag, the interrupt and the overrun output are 0. The engine starts polling the descriptor at `desc_base`.
- R2: Descriptor n occupies words `desc_base+4n` to `+4n+3` (modulo table size). In word 0, bit 15 is Empty, bit 13 is Last (wrap), bit 12 is Notify, bit 9 is Keep (continuous) and bit 1 is Overrun; the other bits are written back as 0. Word 1 receives the byte count. Word 3 holds the buffer address, of which the low address bits of the data memory are used, and word 2 is not read.
- R3: A descriptor with Empty = 0 is never modified by the engine, and neither is its buffer. The engine keeps polling it until the host sets Empty.
- R4: Received bytes are stored in arrival order at buffer address + 0, +1, and so on. When the count reaches `max_len`, the descriptor closes with count = `max_len` and Overrun = 0.
- R5: After closing a descriptor with Last = 1, the next descriptor used is the one at `desc_base`. Otherwise it is the next one in the table.
- R6: On an error-free close, Empty is written back as the descriptor's Keep bit. Last, Notify and Keep are written back unchanged.
- R7: The event flag is set only by a close caused by a full buffer whose Notify bit is 1. It stays set until an `evt_clr` pulse. `irq` equals event AND `evt_mask`, one cycle later.
- R8: A byte that arrives while the holding register is occupied and is not being written to memory that cycle is dropped. `rx_overrun` pulses for one cycle. The current buffer then closes after the held byte has been stored, with Overrun = 1, Empty = 0 even when Keep = 1, and count = bytes stored.
- R9: A `hunt` pulse closes the current buffer with the bytes stored so far, with Overrun = 0. If no byte has been stored, the descriptor stays open and unmodified.
- R10: A host read returns the addressed word on `host_rdata` one cycle later. `host_sel` = 0 selects the descriptor table and 1 selects data memory. Data reads are zero-extended, and data writes store the low byte of `host_wdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| desc_base | input | DESC_AW | Word address of the first descriptor |
| max_len | input | 16 | Byte count at which a buffer is full (at least 1) |
| rx_valid | input | 1 | One received byte is present this cycle |
| rx_byte | input | 8 | Received byte |
| hunt | input | 1 | One-cycle command that closes a partially filled buffer |
| host_sel | input | 1 | 0 selects the descriptor table, 1 selects data memory |
| host_we | input | 1 | Host write strobe |
| host_addr | input | HOST_AW | Host word or byte address |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data, one cycle after the address |
| evt_mask | input | 1 | Enables the event flag onto `irq` |
| evt_clr | input | 1 | Clears the event flag |
| rxb_event | output | 1 | Receive-buffer event flag |
| irq | output | 1 | Masked interrupt |
| rx_overrun | output | 1 | One-cycle pulse per dropped byte |

## Verification
The hardest state to reach from the ports is an overrun that is followed by a close with error on a descriptor that has Keep set. An overrun can only occur while the engine is away from data storage. The bench therefore hands the engine a ring whose next descriptor still belongs to the host. It sends two bytes while the engine polls, so the first byte waits in the holding register and the second is dropped. It then releases that descriptor with Keep and Notify set. It confirms that the held byte is stored, that Overrun is recorded, that Empty is cleared and that no event is raised.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  localparam int WORD_W = 16;
  localparam int F_EMPTY = 15;
  localparam int F_LAST  = 13;
  localparam int F_NOTE  = 12;
  localparam int F_KEEP  = 9;
  localparam int F_OVR   = 1;

  typedef enum logic [2:0] {
    ST_POLL, ST_CHECK, ST_ADDR, ST_FILL, ST_CLOSE_LEN, ST_CLOSE_STAT
  } rxr_state_t;
endpackage

// File: rtl/rxr_ram.sv
module rxr_ram #(
  parameter int W  = 16,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          a_we,
  input  logic [AW-1:0] a_addr,
  input  logic [W-1:0]  a_wdata,
  output logic [W-1:0]  a_rdata,
  input  logic          b_we,
  input  logic [AW-1:0] b_addr,
  input  logic [W-1:0]  b_wdata,
  output logic [W-1:0]  b_rdata
);
  localparam int DEPTH = 1 << AW;
  logic [W-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
  end

  // port b (engine) is written last, so it wins a same-address collision
  always_ff @(posedge clk) begin
    if (a_we) mem[a_addr] <= a_wdata;
    if (b_we) mem[b_addr] <= b_wdata;
    a_rdata <= mem[a_addr];
    b_rdata <= mem[b_addr];
  end
endmodule

// File: rtl/rxr_event.sv
module rxr_event (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  input  logic mask,
  output logic evt,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (rst) begin
      evt <= 1'b0;
      irq <= 1'b0;
    end else begin
      if (clr) evt <= 1'b0;
      if (set) evt <= 1'b1;
      irq <= evt & mask;
    end
  end

  a_r7_irq_needs_mask: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(mask));
  a_r7_event_sticky: assert property (@(posedge clk) disable iff (rst)
    (evt && !clr) |=> evt);
endmodule

// File: rtl/rxr_engine.sv
module rxr_engine
  import rxr_pkg::*;
#(
  parameter int DESC_AW = 6,
  parameter int DATA_AW = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [DESC_AW-1:0] desc_base,
  input  logic [WORD_W-1:0]  max_len,
  input  logic               rx_valid,
  input  logic [7:0]         rx_byte,
  input  logic               hunt,
  output logic [DESC_AW-1:0] d_addr,
  output logic               d_we,
  output logic [WORD_W-1:0]  d_wdata,
  input  logic [WORD_W-1:0]  d_rdata,
  output logic [DATA_AW-1:0] m_addr,
  output logic               m_we,
  output logic [7:0]         m_wdata,
  output logic               evt_set,
  output logic               ovr_pulse
);
  rxr_state_t         st;
  logic [DESC_AW-1:0] cur;
  logic [DATA_AW-1:0] bptr;
  logic [WORD_W-1:0]  cnt;
  logic               c_last, c_note, c_keep;
  logic               hold_v;
  logic [7:0]         hold_b;
  logic               ovr_flag, hunt_pend;
  logic               cl_full, cl_ovr;
  logic [WORD_W-1:0]  stat_word;
  logic               unused_ok;

  assign unused_ok = ^d_rdata;

  always_comb begin
    stat_word          = '0;
    stat_word[F_EMPTY] = c_keep & ~cl_ovr;
    stat_word[F_LAST]  = c_last;
    stat_word[F_NOTE]  = c_note;
    stat_word[F_KEEP]  = c_keep;
    stat_word[F_OVR]   = cl_ovr;
  end

  always_comb begin
    d_addr  = cur;
    d_we    = 1'b0;
    d_wdata = '0;
    case (st)
      ST_CHECK:      d_addr = cur + DESC_AW'(3);
      ST_CLOSE_LEN:  begin d_addr = cur + DESC_AW'(1); d_we = 1'b1; d_wdata = cnt; end
      ST_CLOSE_STAT: begin d_we = 1'b1; d_wdata = stat_word; end
      default: ;
    endcase
  end

  assign m_we    = (st == ST_FILL) && hold_v;
  assign m_addr  = bptr + cnt[DATA_AW-1:0];
  assign m_wdata = hold_b;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_POLL; cur <= desc_base; bptr <= '0; cnt <= '0;
      c_last <= 1'b0; c_note <= 1'b0; c_keep <= 1'b0;
      hold_v <= 1'b0; hold_b <= '0; ovr_flag <= 1'b0; hunt_pend <= 1'b0;
      cl_full <= 1'b0; cl_ovr <= 1'b0; evt_set <= 1'b0; ovr_pulse <= 1'b0;
    end else begin
      evt_set   <= 1'b0;
      ovr_pulse <= 1'b0;
      case (st)
        ST_POLL:  st <= ST_CHECK;
        ST_CHECK: begin
          if (d_rdata[F_EMPTY]) begin
            c_last <= d_rdata[F_LAST];
            c_note <= d_rdata[F_NOTE];
            c_keep <= d_rdata[F_KEEP];
            st     <= ST_ADDR;
          end else begin
            st <= ST_POLL;
          end
        end
        ST_ADDR: begin
          bptr <= d_rdata[DATA_AW-1:0];
          cnt  <= '0;
          st   <= ST_FILL;
        end
        ST_FILL: begin
          if (hold_v) begin
            cnt <= cnt + WORD_W'(1);
            if (cnt + WORD_W'(1) == max_len) begin
              cl_full <= 1'b1; cl_ovr <= ovr_flag;
              ovr_flag <= 1'b0; hunt_pend <= 1'b0; st <= ST_CLOSE_LEN;
            end
          end else if (ovr_flag) begin
            cl_full <= 1'b0; cl_ovr <= 1'b1;
            ovr_flag <= 1'b0; hunt_pend <= 1'b0; st <= ST_CLOSE_LEN;
          end else if (hunt_pend) begin
            hunt_pend <= 1'b0;
            if (cnt != '0) begin
              cl_full <= 1'b0; cl_ovr <= 1'b0; st <= ST_CLOSE_LEN;
            end
          end
        end
        ST_CLOSE_LEN: st <= ST_CLOSE_STAT;
        ST_CLOSE_STAT: begin
          evt_set <= cl_full & c_note;
          cur     <= c_last ? desc_base : cur + DESC_AW'(4);
          st      <= ST_POLL;
        end
        default: st <= ST_POLL;
      endcase
      // holding register: drained only while filling
      if (rx_valid) begin
        if (hold_v && !m_we) begin
          ovr_pulse <= 1'b1;
          ovr_flag  <= 1'b1;
        end else begin
          hold_b <= rx_byte;
          hold_v <= 1'b1;
        end
      end else if (m_we) begin
        hold_v <= 1'b0;
      end
      if (hunt) hunt_pend <= 1'b1;
    end
  end

  a_r3_host_owned_waits: assert property (@(posedge clk) disable iff (rst)
    (st == ST_CHECK && !d_rdata[F_EMPTY]) |=> (st == ST_POLL));
  a_r4_no_overfill: assert property (@(posedge clk) disable iff (rst)
    m_we |-> (cnt < max_len));
  a_r5_last_returns_to_base: assert property (@(posedge clk) disable iff (rst)
    (st == ST_CLOSE_STAT && c_last) |=> (cur == $past(desc_base)));
  a_r8_drop_reported: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && hold_v && st != ST_FILL) |=> ovr_pulse);
  a_r8_count_then_status: assert property (@(posedge clk) disable iff (rst)
    (st == ST_CLOSE_LEN) |=> (st == ST_CLOSE_STAT));
endmodule

// File: rtl/rxbd_ring.sv
module rxbd_ring
  import rxr_pkg::*;
#(
  parameter int DESC_AW = 6,
  parameter int DATA_AW = 8,
  localparam int HOST_AW = (DESC_AW > DATA_AW) ? DESC_AW : DATA_AW
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [DESC_AW-1:0] desc_base,
  input  logic [15:0]        max_len,
  input  logic               rx_valid,
  input  logic [7:0]         rx_byte,
  input  logic               hunt,
  input  logic               host_sel,
  input  logic               host_we,
  input  logic [HOST_AW-1:0] host_addr,
  input  logic [15:0]        host_wdata,
  output logic [15:0]        host_rdata,
  input  logic               evt_mask,
  input  logic               evt_clr,
  output logic               rxb_event,
  output logic               irq,
  output logic               rx_overrun
);
  logic [DESC_AW-1:0] d_addr;
  logic               d_we;
  logic [WORD_W-1:0]  d_wdata, d_rdata, dh_rdata;
  logic [DATA_AW-1:0] m_addr;
  logic               m_we;
  logic [7:0]         m_wdata, mh_rdata, dm_b_unused;
  logic               evt_set;
  logic               sel_q;
  logic               unused_ok;

  assign unused_ok = ^{host_addr, host_wdata};

  always_ff @(posedge clk) begin
    if (rst) sel_q <= 1'b0;
    else     sel_q <= host_sel;
  end
  assign host_rdata = sel_q ? {8'h00, mh_rdata} : dh_rdata;

  rxr_ram #(.W(WORD_W), .AW(DESC_AW)) u_desc (
    .clk(clk),
    .a_we(host_we & ~host_sel), .a_addr(host_addr[DESC_AW-1:0]),
    .a_wdata(host_wdata), .a_rdata(dh_rdata),
    .b_we(d_we), .b_addr(d_addr), .b_wdata(d_wdata), .b_rdata(d_rdata)
  );

  rxr_ram #(.W(8), .AW(DATA_AW)) u_data (
    .clk(clk),
    .a_we(host_we & host_sel), .a_addr(host_addr[DATA_AW-1:0]),
    .a_wdata(host_wdata[7:0]), .a_rdata(mh_rdata),
    .b_we(m_we), .b_addr(m_addr), .b_wdata(m_wdata), .b_rdata(dm_b_unused)
  );

  rxr_engine #(.DESC_AW(DESC_AW), .DATA_AW(DATA_AW)) u_eng (
    .clk(clk), .rst(rst), .desc_base(desc_base), .max_len(max_len),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .hunt(hunt),
    .d_addr(d_addr), .d_we(d_we), .d_wdata(d_wdata), .d_rdata(d_rdata),
    .m_addr(m_addr), .m_we(m_we), .m_wdata(m_wdata),
    .evt_set(evt_set), .ovr_pulse(rx_overrun)
  );

  rxr_event u_evt (
    .clk(clk), .rst(rst), .set(evt_set), .clr(evt_clr), .mask(evt_mask),
    .evt(rxb_event), .irq(irq)
  );
endmodule

// File: tb/tb_rxbd_ring.sv
module tb_rxbd_ring;
  localparam int DESC_AW = 6;
  localparam int DATA_AW = 8;
  localparam int HOST_AW = 8;
  localparam int BASE = 8;
  localparam int NV = 8;
  localparam logic [7:0] VEC [NV] = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66, 8'h77, 8'h88};
  localparam logic [7:0] PTRS [3] = '{8'h10, 8'h20, 8'h30};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [DESC_AW-1:0] desc_base = DESC_AW'(BASE);
  logic [15:0] max_len = 16'd3;
  logic rx_valid = 1'b0;
  logic [7:0] rx_byte = '0;
  logic hunt = 1'b0;
  logic host_sel = 1'b0, host_we = 1'b0;
  logic [HOST_AW-1:0] host_addr = '0;
  logic [15:0] host_wdata = '0;
  logic [15:0] host_rdata;
  logic evt_mask = 1'b1, evt_clr = 1'b0;
  logic rxb_event, irq, rx_overrun;

  int n_checks = 0;
  int n_fail = 0;
  logic ov_seen;
  logic [15:0] rd;

  always #4 clk = ~clk;

  rxbd_ring #(.DESC_AW(DESC_AW), .DATA_AW(DATA_AW)) dut (
    .clk(clk), .rst(rst), .desc_base(desc_base), .max_len(max_len),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .hunt(hunt),
    .host_sel(host_sel), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .evt_mask(evt_mask), .evt_clr(evt_clr),
    .rxb_event(rxb_event), .irq(irq), .rx_overrun(rx_overrun)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic hwrite(input logic sel, input int addr, input logic [15:0] val);
    @(negedge clk);
    host_sel = sel; host_addr = HOST_AW'(addr); host_wdata = val; host_we = 1'b1;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic hread(input logic sel, input int addr, output logic [15:0] val);
    @(negedge clk);
    host_sel = sel; host_addr = HOST_AW'(addr); host_we = 1'b0;
    @(negedge clk);
    val = host_rdata;
  endtask

  task automatic send(input logic [7:0] b, output logic ov);
    @(negedge clk);
    rx_valid = 1'b1; rx_byte = b;
    @(negedge clk);
    rx_valid = 1'b0;
    ov = rx_overrun;
    repeat (6) @(negedge clk);
  endtask

  task automatic pulse_hunt();
    @(negedge clk); hunt = 1'b1;
    @(negedge clk); hunt = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    idle(3);
    rst = 1'b0;
    // R1: reset state
    check("R1 event", {15'd0, rxb_event}, 16'd0);
    check("R1 irq", {15'd0, irq}, 16'd0);
    check("R1 overrun", {15'd0, rx_overrun}, 16'd0);
    hread(1'b0, BASE, rd); check("R1 base word", rd, 16'h0000);

    // set up three descriptors: Notify, Notify, Last
    hwrite(1'b0, BASE + 3, 16'h0010); hwrite(1'b0, BASE + 0, 16'h9000);
    hwrite(1'b0, BASE + 7, 16'h0020); hwrite(1'b0, BASE + 4, 16'h9000);
    hwrite(1'b0, BASE + 11, 16'h0030); hwrite(1'b0, BASE + 8, 16'hA000);
    idle(10);
    for (int i = 0; i < NV; i++) begin
      send(VEC[i], ov_seen);
      check("R8 no drop on spaced bytes", {15'd0, ov_seen}, 16'd0);
    end
    pulse_hunt();
    idle(12);
    for (int i = 0; i < NV; i++) begin
      hread(1'b1, PTRS[i / 3] + (i % 3), rd);
      check("R4 stored byte order", rd, {8'h00, VEC[i]});
    end
    hread(1'b0, BASE + 0, rd); check("R6 close clears Empty", rd, 16'h1000);
    hread(1'b0, BASE + 1, rd); check("R4 full count", rd, 16'd3);
    hread(1'b0, BASE + 4, rd); check("R6 second status", rd, 16'h1000);
    hread(1'b0, BASE + 5, rd); check("R4 second count", rd, 16'd3);
    hread(1'b0, BASE + 8, rd); check("R9 hunt close status", rd, 16'h2000);
    hread(1'b0, BASE + 9, rd); check("R9 hunt close count", rd, 16'd2);
    check("R7 event after full Notify", {15'd0, rxb_event}, 16'd1);
    check("R7 irq when masked in", {15'd0, irq}, 16'd1);
    @(negedge clk); evt_mask = 1'b0; idle(2);
    check("R7 irq masked off", {15'd0, irq}, 16'd0);
    evt_mask = 1'b1;
    @(negedge clk); evt_clr = 1'b1; @(negedge clk); evt_clr = 1'b0; idle(2);
    check("R7 event cleared", {15'd0, rxb_event}, 16'd0);
    check("R7 irq cleared", {15'd0, irq}, 16'd0);

    // R5: after Last the engine returns to base; R6: Keep leaves Empty set
    hwrite(1'b0, BASE + 3, 16'h0040); hwrite(1'b0, BASE + 0, 16'h8200);
    idle(8);
    send(8'hC1, ov_seen); send(8'hC2, ov_seen); send(8'hC3, ov_seen);
    idle(10);
    hread(1'b1, 16'h40, rd); check("R5 wrap to base buffer", rd, 16'h00C1);
    hread(1'b1, 16'h42, rd); check("R5 wrap third byte", rd, 16'h00C3);
    hread(1'b0, BASE + 0, rd); check("R6 Keep leaves Empty", rd, 16'h8200);
    hread(1'b0, BASE + 1, rd); check("R4 count on Keep buffer", rd, 16'd3);
    check("R7 no event without Notify", {15'd0, rxb_event}, 16'd0);

    // R3/R8: next descriptor is host-owned; bytes wait, second one dropped
    send(8'hD1, ov_seen); check("R8 first byte held", {15'd0, ov_seen}, 16'd0);
    send(8'hD2, ov_seen); check("R8 second byte dropped", {15'd0, ov_seen}, 16'd1);
    hread(1'b0, BASE + 4, rd); check("R3 host-owned status untouched", rd, 16'h1000);
    hread(1'b0, BASE + 5, rd); check("R3 host-owned count untouched", rd, 16'd3);
    hread(1'b1, 16'h20, rd); check("R3 host-owned buffer untouched", rd, {8'h00, VEC[3]});
    hwrite(1'b0, BASE + 7, 16'h0050); hwrite(1'b0, BASE + 4, 16'h9200);
    idle(20);
    hread(1'b0, BASE + 4, rd); check("R8 error clears Empty despite Keep", rd, 16'h1202);
    hread(1'b0, BASE + 5, rd); check("R8 count of stored bytes", rd, 16'd1);
    hread(1'b1, 16'h50, rd); check("R8 held byte stored", rd, 16'h00D1);
    hread(1'b1, 16'h51, rd); check("R8 dropped byte absent", rd, 16'h0000);
    check("R7 no event on overrun close", {15'd0, rxb_event}, 16'd0);

    // R9: hunt on an empty buffer leaves it open
    hwrite(1'b0, BASE + 9, 16'h0077); hwrite(1'b0, BASE + 11, 16'h0060);
    hwrite(1'b0, BASE + 8, 16'hA000);
    idle(10);
    pulse_hunt(); idle(10);
    hread(1'b0, BASE + 8, rd); check("R9 empty hunt keeps status", rd, 16'hA000);
    hread(1'b0, BASE + 9, rd); check("R9 empty hunt keeps count", rd, 16'h0077);
    send(8'hE1, ov_seen); idle(4);
    pulse_hunt(); idle(10);
    hread(1'b0, BASE + 8, rd); check("R9 hunt closes one byte", rd, 16'h2000);
    hread(1'b0, BASE + 9, rd); check("R9 hunt count one", rd, 16'd1);
    hread(1'b1, 16'h60, rd); check("R9 byte stored", rd, 16'h00E1);

    // R10: host data port stores low byte, reads zero-extended
    hwrite(1'b1, 16'hF0, 16'h12AB);
    hread(1'b1, 16'hF0, rd); check("R10 data zero-extended", rd, 16'h00AB);
    hwrite(1'b0, 60, 16'hBEEF);
    hread(1'b0, 60, rd); check("R10 table word readback", rd, 16'hBEEF);
    // R2: word 2 of a descriptor is never read nor written
    hread(1'b0, BASE + 2, rd); check("R2 word two untouched", rd, 16'h0000);

    summary();
    $finish;
  end
endmodule